// File: doc/BRIEF.md
# Cascadable Up/Down Extension Counter

This block is an 8-bit up/down counter meant to sit above a lower counter stage and widen it. Two active-low strobes drive it: one requests an increment and one a decrement. In a chain these are the carry and borrow pulses of the stage below. A count takes place when one strobe returns high while the other strobe rests high.

The block gives the next stage active-low carry and borrow pulses. A carry pulse starts when the increment strobe falls with the count at all ones. A borrow pulse starts when the decrement strobe falls with the count at zero, or while the clear input is held. Either pulse ends on the rising edge that performs the count. The count therefore wraps, and the outgoing pulse lasts about as long as the incoming strobe was low.

The strobes and the active-high clear come from outside the clock domain. Each passes through a two-flop synchronizer before edge detection, so a strobe edge at a port reaches the count three clock edges later. A busy flag shows that a count strobe is in progress, for use by a separate strobe latch.

Top module: `ext_updown_counter`

## Requirements
- R1: A rising edge on `inc_n` while `dec_n` is high raises `count` by one.
- R2: A rising edge on `dec_n` while `inc_n` is high lowers `count` by one.
- R3: When `inc_n` falls while `dec_n` is high and `count` is 8'hFF, `carry_n` goes low. It stays low while `inc_n` is low and returns high on the rising edge that wraps `count` to 8'h00.
- R4: When `dec_n` falls while `inc_n` is high and `count` is 8'h00, `borrow_n` goes low. It stays low while `dec_n` is low and returns high on the rising edge that wraps `count` to 8'hFF.
- R5: While `clear` is high, `count` is 8'h00 and strobe edges do not change it. `carry_n` stays high.
- R6: A decrement strobe issued while `clear` is high still drives `borrow_n` low for its low period.
- R7: When both strobes are low together and then rise in the same cycle, `count` does not change and neither `carry_n` nor `borrow_n` goes low.
- R8: `count_busy` is 1 whenever either synchronized strobe is low and 0 when both are high. `carry_n` and `borrow_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| inc_n | input | 1 | Active-low increment strobe; counts on its rising edge |
| dec_n | input | 1 | Active-low decrement strobe; counts on its rising edge |
| clear | input | 1 | Active-high counter clear, asynchronous to clk |
| count | output | 8 | Current count value |
| carry_n | output | 1 | Active-low carry pulse to the next stage |
| borrow_n | output | 1 | Active-low borrow pulse to the next stage |
| count_busy | output | 1 | High while a count strobe is low |

## Verification
The bench drives single increment and decrement strobes from random count values. Comparing `count` before and after each rising edge separates the two count directions and shows that nothing is counted while a strobe is merely low. Directed strobes at 8'hFF and 8'h00 show whether the carry and borrow pulses track the strobe low period and whether the wrap value is right. Strobes issued under `clear` check the borrow-during-clear rule against frozen counting. A simultaneous low on both strobes followed by a simultaneous release distinguishes a correctly rejected ambiguous request from a stray count or pulse.

// File: rtl/extcnt_pkg.sv
package extcnt_pkg;
    localparam int STB_INC = 0;
    localparam int STB_DEC = 1;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } strobe_ev_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect
    import extcnt_pkg::*;
#(
    parameter int             N    = 2,
    parameter logic [N-1:0]   IDLE = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          lvl_i,
    output strobe_ev_t [N-1:0]    ev_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= IDLE;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_ev
        always_comb begin
            ev_o[i].lvl  = lvl_i[i];
            ev_o[i].rise = lvl_i[i] && !prev_q[i];
            ev_o[i].fall = !lvl_i[i] && prev_q[i];
        end
    end
endmodule

// File: rtl/count_core.sv
module count_core
    import extcnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  strobe_ev_t       inc_ev,
    input  strobe_ev_t       dec_ev,
    input  logic             clr,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o,
    output logic             busy_o
);
    localparam logic [WIDTH-1:0] MAX_VAL = '1;
    localparam logic [WIDTH-1:0] MIN_VAL = '0;

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             carry_n;
        logic             borrow_n;
        logic             busy;
    } core_st_t;

    core_st_t st_d, st_q;
    logic inc_go, dec_go;

    always_comb begin
        st_d   = st_q;
        inc_go = inc_ev.rise && dec_ev.lvl && !dec_ev.rise;
        dec_go = dec_ev.rise && inc_ev.lvl && !inc_ev.rise;

        st_d.busy = !inc_ev.lvl || !dec_ev.lvl;

        if (clr) begin
            st_d.count = MIN_VAL;
        end else if (inc_go) begin
            st_d.count = st_q.count + 1'b1;
        end else if (dec_go) begin
            st_d.count = st_q.count - 1'b1;
        end

        if (inc_ev.fall && dec_ev.lvl && !dec_ev.fall && !clr && st_q.count == MAX_VAL) begin
            st_d.carry_n = 1'b0;
        end else if (inc_ev.rise || clr) begin
            st_d.carry_n = 1'b1;
        end

        if (dec_ev.fall && inc_ev.lvl && !inc_ev.fall && (clr || st_q.count == MIN_VAL)) begin
            st_d.borrow_n = 1'b0;
        end else if (dec_ev.rise) begin
            st_d.borrow_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: MIN_VAL, carry_n: 1'b1, borrow_n: 1'b1, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.count;
    assign carry_n_o  = st_q.carry_n;
    assign borrow_n_o = st_q.borrow_n;
    assign busy_o     = st_q.busy;

    assert_inc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ev.rise && dec_ev.lvl && !dec_ev.rise && !clr) |=> count_o == $past(count_o) + 1'b1);

    assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ev.rise && inc_ev.lvl && !inc_ev.rise && !clr) |=> count_o == $past(count_o) - 1'b1);

    assert_carry_at_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carry_n_o) |-> count_o == MAX_VAL);

    assert_carry_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_n_o && inc_ev.rise) |=> carry_n_o);

    assert_borrow_at_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(borrow_n_o) |-> count_o == MIN_VAL);

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_o == MIN_VAL && carry_n_o));

    assert_both_low_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_ev.lvl && !dec_ev.lvl && !clr) |=> $stable(count_o));

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!carry_n_o, !borrow_n_o}));
endmodule

// File: rtl/ext_updown_counter.sv
module ext_updown_counter
    import extcnt_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_n,
    input  logic             dec_n,
    input  logic             clear,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n,
    output logic             count_busy
);
    localparam int NSTB = 2;
    localparam int NSIG = NSTB + 1;

    logic [NSIG-1:0]       raw_in, synced;
    strobe_ev_t [NSTB-1:0] ev;

    assign raw_in = {clear, dec_n, inc_n};

    strobe_sync #(
        .WIDTH   (NSIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b0, {NSTB{1'b1}}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    edge_detect #(
        .N    (NSTB),
        .IDLE ({NSTB{1'b1}})
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (synced[NSTB-1:0]),
        .ev_o  (ev)
    );

    count_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_ev     (ev[STB_INC]),
        .dec_ev     (ev[STB_DEC]),
        .clr        (synced[NSTB]),
        .count_o    (count),
        .carry_n_o  (carry_n),
        .borrow_n_o (borrow_n),
        .busy_o     (count_busy)
    );
endmodule

// File: tb/ext_updown_counter_bench.sv
module ext_updown_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inc_n = 1'b1;
    logic       dec_n = 1'b1;
    logic       clear = 1'b0;
    logic [7:0] count;
    logic       carry_n, borrow_n, count_busy;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_cnt = 8'h00;
    logic       clr_on = 1'b0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_updown_counter u_ext_updown_counter (
        .clk(clk), .rst_n(rst_n), .inc_n(inc_n), .dec_n(dec_n), .clear(clear),
        .count(count), .carry_n(carry_n), .borrow_n(borrow_n), .count_busy(count_busy)
    );

    function automatic logic [7:0] next_inc(logic [7:0] c, logic clr);
        return clr ? 8'h00 : c + 8'h01;
    endfunction

    function automatic logic [7:0] next_dec(logic [7:0] c, logic clr);
        return clr ? 8'h00 : c - 8'h01;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_inc();
        inc_n = 1'b0;
        settle();
        check("R8 busy during inc", count_busy, 1);
        check("R1 count held while low", count, exp_cnt);
        check("R3 carry during low", carry_n, (!clr_on && exp_cnt == 8'hFF) ? 0 : 1);
        check("R8 no borrow on inc", borrow_n, 1);
        inc_n = 1'b1;
        settle();
        exp_cnt = next_inc(exp_cnt, clr_on);
        check("R1 count after inc", count, exp_cnt);
        check("R3 carry released", carry_n, 1);
        check("R8 busy idle", count_busy, 0);
    endtask

    task automatic do_dec();
        dec_n = 1'b0;
        settle();
        check("R8 busy during dec", count_busy, 1);
        check("R2 count held while low", count, exp_cnt);
        check("R4 R6 borrow during low", borrow_n, (clr_on || exp_cnt == 8'h00) ? 0 : 1);
        check("R8 no carry on dec", carry_n, 1);
        dec_n = 1'b1;
        settle();
        exp_cnt = next_dec(exp_cnt, clr_on);
        check("R2 count after dec", count, exp_cnt);
        check("R4 borrow released", borrow_n, 1);
    endtask

    task automatic do_both();
        inc_n = 1'b0;
        dec_n = 1'b0;
        settle();
        check("R8 busy both low", count_busy, 1);
        check("R7 no carry both low", carry_n, 1);
        check("R7 no borrow both low", borrow_n, 1);
        inc_n = 1'b1;
        dec_n = 1'b1;
        settle();
        check("R7 count unchanged", count, exp_cnt);
    endtask

    task automatic set_clear(logic v);
        clear = v;
        clr_on = v;
        settle();
        if (v) exp_cnt = 8'h00;
        check("R5 count under clear", count, exp_cnt);
        check("R5 carry high under clear", carry_n, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R5 reset count", count, 8'h00);
        check("R3 reset carry", carry_n, 1);
        check("R4 reset borrow", borrow_n, 1);
        check("R8 reset busy", count_busy, 0);

        do_dec();                          // R4 wrap 00 -> FF
        check("R4 wrapped to FF", count, 8'hFF);
        do_inc();                          // R3 wrap FF -> 00
        check("R3 wrapped to 00", count, 8'h00);
        do_inc();
        do_inc();
        set_clear(1'b1);                   // R5
        do_dec();                          // R6 borrow during clear
        do_inc();                          // R5 no count under clear
        set_clear(1'b0);
        do_inc();
        do_both();                         // R7
        do_dec();
        do_both();

        for (int i = 0; i < 300; i++) begin
            int sel = int'($urandom_range(0, 19));
            if (sel < 8) do_inc();
            else if (sel < 16) do_dec();
            else if (sel < 18) do_both();
            else if (sel == 18) set_clear(1'b1);
            else set_clear(1'b0);
        end
        set_clear(1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule